// File: doc/BRIEF.md
# Interrupt Stack Entry and Return Sequencer

This block is the multi-cycle engine that an 8-bit processor core with a 16-bit program counter and an 8-bit stack pointer uses to save and restore its context. There are two entry paths: a hardware interrupt and a software break. On entry the block saves the return address and the status byte on the stack through a byte-wide memory port. It then marks interrupts as disabled and loads the new program counter from a two-byte vector. There are two return paths: return from interrupt and return from subroutine. On return the block reads the saved bytes back and rebuilds the program counter, the status byte and the stack pointer.

The core starts a sequence with a one-cycle request strobe and a two-bit kind code. With the strobe it presents its current program counter, status byte, stack pointer and vector address. The block drives the memory address, the write data and the read and write strobes by itself until the sequence ends. At the end it pulses `done` and presents the updated register values. The stack occupies one fixed 256-byte page whose high address byte is a parameter. The stack pointer wraps within that page. Choosing between several interrupt sources is left to logic outside this block.

Top module: `irq_stack_seq`

## Requirements
- R1: While reset is high and in the cycle after it, `busy`, `done`, `mem_we` and `mem_re` are 0, and `pc_out`, `ps_out` and `sp_out` are all zero.
- R2: A request with `req_kind` 0 (hardware interrupt) or 1 (break) writes three bytes in three consecutive cycles, starting the cycle after acceptance. The bytes go to stack offsets S, S-1 and S-2 in turn. The data are the PC high byte, then the PC low byte, then the status byte.
- R3: The pushed status byte is `ps_in` with bit 4 forced to 1 for a break and forced to 0 for a hardware interrupt. After entry, `ps_out` equals the pushed byte with bit 2 (interrupt disable) also set.
- R4: After the three pushes, an entry reads the vector address and then the vector address plus one. `pc_out` becomes {byte at vector+1, byte at vector}, and `sp_out` becomes S-3.
- R5: `req_kind` 2 (return from interrupt) reads stack offsets S+1, S+2 and S+3 in that order. `ps_out` becomes the first byte read, `pc_out` becomes {third byte, second byte}, and `sp_out` becomes S+3.
- R6: `req_kind` 3 (return from subroutine) reads stack offsets S+1 and S+2. `pc_out` becomes {second byte, first byte} plus one, modulo 2^16. `sp_out` becomes S+2 and `ps_out` equals `ps_in`.
- R7: `done` is high for exactly one cycle. For both entry kinds it is high 6 clock edges after the accepting edge, so the sequence spans 7 cycles. For both return kinds it is high 5 edges after, a span of 6 cycles.
- R8: Every stack access uses address {STACK_PAGE, offset}, and the offset wraps modulo 256 in both directions.
- R9: A request presented while `busy` is high is ignored. It starts no extra memory access once `done` has fallen, and it leaves the outputs unchanged.
- R10: `busy` is high from the cycle after acceptance through the `done` cycle. `pc_out`, `ps_out` and `sp_out` keep their previous values until the `done` cycle, when they show the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted only while idle |
| req_kind | input | 2 | 0 hardware interrupt, 1 break, 2 return from interrupt, 3 return from subroutine |
| pc_in | input | 16 | Current program counter |
| ps_in | input | 8 | Current status byte |
| sp_in | input | 8 | Current stack pointer |
| vec_in | input | 16 | Address of the low byte of the entry vector |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe, data expected on `mem_rdata` in the same cycle |
| mem_rdata | input | 8 | Memory read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Updated program counter |
| ps_out | output | 8 | Updated status byte |
| sp_out | output | 8 | Updated stack pointer |

## Verification
A wrong working stack pointer shows up on `mem_addr` one cycle later, as a push or pop at the wrong offset. The bench sweeps all 256 starting offsets for each kind so that wrap faults are exposed. A wrong state transition changes the number of edges before `done` or the order of the logged accesses, and this is visible within the sequence itself. A wrong B or I stamp, or a missing increment on the subroutine return, first reaches the ports at the `done` cycle. A round trip through entry and then return from interrupt also compares the restored PC and status with what the entry pushed.

// File: rtl/irq_stk_pkg.sv
package irq_stk_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 16;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        KIND_HWIRQ = 2'd0,
        KIND_BREAK = 2'd1,
        KIND_RETI  = 2'd2,
        KIND_RETS  = 2'd3
    } seq_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_PS,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_SETTLE,
        ST_POP_PS,
        ST_POP_LO,
        ST_POP_HI,
        ST_BUMP,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {SP_HOLD, SP_DEC, SP_INC} sp_op_e;
    typedef enum logic [1:0] {SRC_PC_HI, SRC_PC_LO, SRC_PS} wsrc_e;
    typedef enum logic [1:0] {ASEL_STACK, ASEL_VEC_LO, ASEL_VEC_HI} asel_e;
    typedef enum logic [1:0] {DST_NONE, DST_PC_LO, DST_PC_HI, DST_PS} dst_e;

    typedef struct packed {
        logic   wr;
        logic   rd;
        wsrc_e  src;
        asel_e  asel;
        sp_op_e sp_op;
        dst_e   dst;
        logic   set_i;
        logic   publish;
        logic   bump;
    } step_ctrl_t;

    typedef struct packed {
        logic  we;
        logic  re;
        addr_t addr;
        byte_t wdata;
    } bus_op_t;

    function automatic logic is_entry(seq_kind_e k);
        return (k == KIND_HWIRQ) || (k == KIND_BREAK);
    endfunction

    function automatic seq_state_e step_after(seq_state_e s, seq_kind_e k);
        case (s)
            ST_PUSH_HI: return ST_PUSH_LO;
            ST_PUSH_LO: return ST_PUSH_PS;
            ST_PUSH_PS: return ST_VEC_LO;
            ST_VEC_LO:  return ST_VEC_HI;
            ST_VEC_HI:  return ST_DONE;
            ST_SETTLE:  return (k == KIND_RETI) ? ST_POP_PS : ST_POP_LO;
            ST_POP_PS:  return ST_POP_LO;
            ST_POP_LO:  return ST_POP_HI;
            ST_POP_HI:  return (k == KIND_RETI) ? ST_DONE : ST_BUMP;
            ST_BUMP:    return ST_DONE;
            default:    return ST_IDLE;
        endcase
    endfunction

    function automatic addr_t stack_addr(byte_t page, byte_t off);
        return {page, off};
    endfunction

endpackage

// File: rtl/stk_seq_fsm.sv
module stk_seq_fsm
    import irq_stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  seq_kind_e  req_kind,
    output seq_state_e state,
    output seq_kind_e  kind,
    output logic       accept,
    output logic       busy,
    output logic       done
);

    seq_state_e state_nx;

    assign accept = req_valid && (state == ST_IDLE);
    assign busy   = (state != ST_IDLE);
    assign done   = (state == ST_DONE);

    always_comb begin
        if (state == ST_IDLE) begin
            if (accept) begin
                state_nx = is_entry(req_kind) ? ST_PUSH_HI : ST_SETTLE;
            end else begin
                state_nx = ST_IDLE;
            end
        end else begin
            state_nx = step_after(state, kind);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            kind  <= KIND_HWIRQ;
        end else begin
            state <= state_nx;
            if (accept) begin
                kind <= req_kind;
            end
        end
    end

    AST_KIND_HELD: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(kind)); // R9

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

endmodule

// File: rtl/stk_step_decode.sv
module stk_step_decode
    import irq_stk_pkg::*;
(
    input  seq_state_e state,
    input  seq_kind_e  kind,
    output step_ctrl_t ctrl
);

    always_comb begin
        ctrl       = '0;
        ctrl.src   = SRC_PC_HI;
        ctrl.asel  = ASEL_STACK;
        ctrl.sp_op = SP_HOLD;
        ctrl.dst   = DST_NONE;
        case (state)
            ST_PUSH_HI: begin
                ctrl.wr    = 1'b1;
                ctrl.src   = SRC_PC_HI;
                ctrl.sp_op = SP_DEC;
            end
            ST_PUSH_LO: begin
                ctrl.wr    = 1'b1;
                ctrl.src   = SRC_PC_LO;
                ctrl.sp_op = SP_DEC;
            end
            ST_PUSH_PS: begin
                ctrl.wr    = 1'b1;
                ctrl.src   = SRC_PS;
                ctrl.sp_op = SP_DEC;
                ctrl.set_i = 1'b1;
            end
            ST_VEC_LO: begin
                ctrl.rd   = 1'b1;
                ctrl.asel = ASEL_VEC_LO;
                ctrl.dst  = DST_PC_LO;
            end
            ST_VEC_HI: begin
                ctrl.rd      = 1'b1;
                ctrl.asel    = ASEL_VEC_HI;
                ctrl.dst     = DST_PC_HI;
                ctrl.publish = 1'b1;
            end
            ST_SETTLE: begin
                ctrl.sp_op = SP_INC;
            end
            ST_POP_PS: begin
                ctrl.rd    = 1'b1;
                ctrl.dst   = DST_PS;
                ctrl.sp_op = SP_INC;
            end
            ST_POP_LO: begin
                ctrl.rd    = 1'b1;
                ctrl.dst   = DST_PC_LO;
                ctrl.sp_op = SP_INC;
            end
            ST_POP_HI: begin
                ctrl.rd      = 1'b1;
                ctrl.dst     = DST_PC_HI;
                ctrl.publish = (kind == KIND_RETI);
            end
            ST_BUMP: begin
                ctrl.publish = 1'b1;
                ctrl.bump    = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/stk_bus_mux.sv
module stk_bus_mux
    import irq_stk_pkg::*;
#(
    parameter byte_t       STACK_PAGE = 8'h01,
    parameter int unsigned BRK_BIT    = 4
)(
    input  step_ctrl_t ctrl,
    input  seq_kind_e  kind,
    input  addr_t      w_pc,
    input  byte_t      w_ps,
    input  byte_t      w_sp,
    input  addr_t      vec_q,
    output bus_op_t    bus
);

    localparam byte_t BRK_MASK = byte_t'(1 << BRK_BIT);

    byte_t stamped_ps;

    assign stamped_ps = (kind == KIND_BREAK) ? (w_ps | BRK_MASK) : (w_ps & ~BRK_MASK);

    always_comb begin
        bus.we = ctrl.wr;
        bus.re = ctrl.rd;
        case (ctrl.asel)
            ASEL_VEC_LO: bus.addr = vec_q;
            ASEL_VEC_HI: bus.addr = vec_q + addr_t'(1);
            default:     bus.addr = stack_addr(STACK_PAGE, w_sp);
        endcase
        case (ctrl.src)
            SRC_PC_LO: bus.wdata = w_pc[BYTE_W-1:0];
            SRC_PS:    bus.wdata = stamped_ps;
            default:   bus.wdata = w_pc[ADDR_W-1:BYTE_W];
        endcase
        if (!ctrl.wr) begin
            bus.wdata = '0;
        end
    end

endmodule

// File: rtl/stk_work_regs.sv
module stk_work_regs
    import irq_stk_pkg::*;
#(
    parameter int unsigned IEN_BIT = 2
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  addr_t      pc_in,
    input  byte_t      ps_in,
    input  byte_t      sp_in,
    input  addr_t      vec_in,
    input  step_ctrl_t ctrl,
    input  byte_t      rdata,
    input  byte_t      wdata,
    output addr_t      w_pc,
    output byte_t      w_ps,
    output byte_t      w_sp,
    output addr_t      vec_q,
    output addr_t      pub_pc,
    output byte_t      pub_ps,
    output byte_t      pub_sp
);

    localparam byte_t IEN_MASK = byte_t'(1 << IEN_BIT);

    addr_t nxt_pc;

    assign nxt_pc = (ctrl.dst == DST_PC_HI) ? {rdata, w_pc[BYTE_W-1:0]} : w_pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            w_pc   <= '0;
            w_ps   <= '0;
            w_sp   <= '0;
            vec_q  <= '0;
            pub_pc <= '0;
            pub_ps <= '0;
            pub_sp <= '0;
        end else if (accept) begin
            w_pc  <= pc_in;
            w_ps  <= ps_in;
            w_sp  <= sp_in;
            vec_q <= vec_in;
        end else begin
            case (ctrl.sp_op)
                SP_DEC:  w_sp <= w_sp - byte_t'(1);
                SP_INC:  w_sp <= w_sp + byte_t'(1);
                default: begin
                end
            endcase
            if (ctrl.set_i) begin
                w_ps <= wdata | IEN_MASK;
            end
            case (ctrl.dst)
                DST_PC_LO: w_pc[BYTE_W-1:0]      <= rdata;
                DST_PC_HI: w_pc[ADDR_W-1:BYTE_W] <= rdata;
                DST_PS:    w_ps                  <= rdata;
                default: begin
                end
            endcase
            if (ctrl.publish) begin
                pub_pc <= ctrl.bump ? (nxt_pc + addr_t'(1)) : nxt_pc;
                pub_ps <= w_ps;
                pub_sp <= w_sp;
            end
        end
    end

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
    import irq_stk_pkg::*;
#(
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter int unsigned BRK_BIT    = 4,
    parameter int unsigned IEN_BIT    = 2
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic [15:0] pc_in,
    input  logic [7:0]  ps_in,
    input  logic [7:0]  sp_in,
    input  logic [15:0] vec_in,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    output logic        mem_re,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] pc_out,
    output logic [7:0]  ps_out,
    output logic [7:0]  sp_out
);

    seq_state_e state;
    seq_kind_e  kind;
    logic       accept;
    step_ctrl_t ctrl;
    bus_op_t    bus;
    addr_t      w_pc;
    byte_t      w_ps;
    byte_t      w_sp;
    addr_t      vec_q;

    stk_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_kind  (seq_kind_e'(req_kind)),
        .state     (state),
        .kind      (kind),
        .accept    (accept),
        .busy      (busy),
        .done      (done)
    );

    stk_step_decode u_dec (
        .state (state),
        .kind  (kind),
        .ctrl  (ctrl)
    );

    stk_bus_mux #(
        .STACK_PAGE (STACK_PAGE),
        .BRK_BIT    (BRK_BIT)
    ) u_bus (
        .ctrl  (ctrl),
        .kind  (kind),
        .w_pc  (w_pc),
        .w_ps  (w_ps),
        .w_sp  (w_sp),
        .vec_q (vec_q),
        .bus   (bus)
    );

    stk_work_regs #(
        .IEN_BIT (IEN_BIT)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .pc_in  (pc_in),
        .ps_in  (ps_in),
        .sp_in  (sp_in),
        .vec_in (vec_in),
        .ctrl   (ctrl),
        .rdata  (mem_rdata),
        .wdata  (bus.wdata),
        .w_pc   (w_pc),
        .w_ps   (w_ps),
        .w_sp   (w_sp),
        .vec_q  (vec_q),
        .pub_pc (pc_out),
        .pub_ps (ps_out),
        .pub_sp (sp_out)
    );

    assign mem_addr  = bus.addr;
    assign mem_wdata = bus.wdata;
    assign mem_we    = bus.we;
    assign mem_re    = bus.re;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_we && !mem_re)); // R9

    AST_PUSH_DESCEND: assert property (@(posedge clk) disable iff (rst)
        ($past(mem_we) && mem_we) |-> (mem_addr[7:0] == $past(mem_addr[7:0]) - 8'd1)); // R2

    AST_STACK_PAGE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr[15:8] == STACK_PAGE)); // R8

    AST_ENTRY_IDIS: assert property (@(posedge clk) disable iff (rst)
        (done && is_entry(kind)) |-> ps_out[IEN_BIT]); // R3

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (done || ($stable(pc_out) && $stable(ps_out) && $stable(sp_out)))); // R10

endmodule

// File: tb/irq_stack_seq_tb.sv
module irq_stack_seq_tb;

    localparam logic [7:0]  PAGE = 8'h01;
    localparam logic [15:0] VEC  = 16'hFFFC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] pc_in = '0;
    logic [7:0]  ps_in = '0;
    logic [7:0]  sp_in = '0;
    logic [15:0] vec_in = VEC;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        mem_re;
    logic [7:0]  mem_rdata;
    logic        busy;
    logic        done;
    logic [15:0] pc_out;
    logic [7:0]  ps_out;
    logic [7:0]  sp_out;

    logic [7:0]  stk [256];
    logic [7:0]  vlo = 8'h00;
    logic [7:0]  vhi = 8'h00;

    logic [15:0] wlog_a [8];
    logic [7:0]  wlog_d [8];
    logic [15:0] rlog_a [8];
    int          nw;
    int          nr;
    int          n_edges;
    int          n_chk  = 0;
    int          n_fail = 0;
    int          cyc    = 0;

    always #2 clk = ~clk;

    irq_stack_seq #(.STACK_PAGE(PAGE)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .pc_in     (pc_in),
        .ps_in     (ps_in),
        .sp_in     (sp_in),
        .vec_in    (vec_in),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .done      (done),
        .pc_out    (pc_out),
        .ps_out    (ps_out),
        .sp_out    (sp_out)
    );

    always_comb begin
        if (mem_addr[15:8] == PAGE)       mem_rdata = stk[mem_addr[7:0]];
        else if (mem_addr == VEC)          mem_rdata = vlo;
        else if (mem_addr == VEC + 16'd1)  mem_rdata = vhi;
        else                               mem_rdata = 8'h00;
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Runs one sequence; logs memory traffic and checks R10 output hold.
    task automatic run_op(input logic [1:0] k, input logic [15:0] pc, input logic [7:0] ps,
                          input logic [7:0] sp, input bit inject);
        logic [15:0] p_pc;
        logic [7:0]  p_ps;
        logic [7:0]  p_sp;
        bit          held;
        bit          busy_ok;
        p_pc = pc_out; p_ps = ps_out; p_sp = sp_out;
        held = 1'b1; busy_ok = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; pc_in = pc; ps_in = ps; sp_in = sp;
        @(posedge clk);
        nw = 0; nr = 0; n_edges = 1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && n_edges < 20) begin
            if (!busy) busy_ok = 1'b0;
            if (pc_out != p_pc || ps_out != p_ps || sp_out != p_sp) held = 1'b0;
            if (mem_we && nw < 8) begin
                wlog_a[nw] = mem_addr; wlog_d[nw] = mem_wdata;
                stk[mem_addr[7:0]] = mem_wdata;
                nw = nw + 1;
            end
            if (mem_re && nr < 8) begin
                rlog_a[nr] = mem_addr; nr = nr + 1;
            end
            req_valid = (inject && n_edges == 2) ? 1'b1 : 1'b0;
            req_kind  = inject ? 2'd1 : k;
            @(posedge clk);
            n_edges = n_edges + 1;
            @(negedge clk);
        end
        req_valid = 1'b0;
        if (!busy) busy_ok = 1'b0;
        chk(held, "R10", "outputs held before done", {15'd0, held}, 1);
        chk(busy_ok, "R10", "busy through sequence", {15'd0, busy_ok}, 1);
        chk(done, "R7", "done reached", {31'd0, done}, 1);
    endtask

    task automatic after_done_checks();
        @(negedge clk);
        chk(!done, "R7", "done single cycle", {31'd0, done}, 0);
        chk(!busy, "R10", "busy drops after done", {31'd0, busy}, 0);
    endtask

    task automatic do_entry(input logic [1:0] k, input logic [7:0] s, input bit inject);
        logic [15:0] pc;
        logic [7:0]  ps;
        logic [7:0]  stamped;
        pc  = 16'hA000 ^ {s, ~s};
        ps  = s ^ 8'h3C;
        vlo = s + 8'h11;
        vhi = ~s;
        stamped = (k == 2'd1) ? (ps | 8'h10) : (ps & 8'hEF);
        run_op(k, pc, ps, s, inject);
        chk(n_edges == 6, "R7", "entry edge count", n_edges, 6);
        chk(nw == 3, "R2", "push count", nw, 3);
        chk(wlog_a[0] == {PAGE, s}, "R8", "push hi addr", wlog_a[0], {PAGE, s});
        chk(wlog_d[0] == pc[15:8], "R2", "push hi data", wlog_d[0], pc[15:8]);
        chk(wlog_a[1] == {PAGE, s - 8'd1}, "R8", "push lo addr", wlog_a[1], {PAGE, s - 8'd1});
        chk(wlog_d[1] == pc[7:0], "R2", "push lo data", wlog_d[1], pc[7:0]);
        chk(wlog_a[2] == {PAGE, s - 8'd2}, "R8", "push ps addr", wlog_a[2], {PAGE, s - 8'd2});
        chk(wlog_d[2] == stamped, "R3", "pushed status", wlog_d[2], stamped);
        chk(nr == 2 && rlog_a[0] == VEC && rlog_a[1] == VEC + 16'd1, "R4", "vector reads",
            rlog_a[0], VEC);
        chk(pc_out == {vhi, vlo}, "R4", "vector pc", pc_out, {vhi, vlo});
        chk(sp_out == s - 8'd3, "R4", "entry sp", sp_out, s - 8'd3);
        chk(ps_out == (stamped | 8'h04), "R3", "entry ps", ps_out, stamped | 8'h04);
        after_done_checks();
    endtask

    task automatic do_reti(input logic [7:0] s);
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] b2;
        b0 = s ^ 8'hA5; b1 = s + 8'h07; b2 = 8'h80 | s;
        stk[s + 8'd1] = b0; stk[s + 8'd2] = b1; stk[s + 8'd3] = b2;
        run_op(2'd2, 16'h1234, 8'h00, s, 1'b0);
        chk(n_edges == 5, "R7", "reti edge count", n_edges, 5);
        chk(nw == 0, "R5", "reti no writes", nw, 0);
        chk(nr == 3 && rlog_a[0] == {PAGE, s + 8'd1} && rlog_a[1] == {PAGE, s + 8'd2}
            && rlog_a[2] == {PAGE, s + 8'd3}, "R8", "reti read order", rlog_a[0], {PAGE, s + 8'd1});
        chk(ps_out == b0, "R5", "reti ps", ps_out, b0);
        chk(pc_out == {b2, b1}, "R5", "reti pc", pc_out, {b2, b1});
        chk(sp_out == s + 8'd3, "R5", "reti sp", sp_out, s + 8'd3);
        after_done_checks();
    endtask

    task automatic do_rets(input logic [7:0] s, input logic [15:0] ret);
        logic [7:0] ps;
        ps = ~s;
        stk[s + 8'd1] = ret[7:0]; stk[s + 8'd2] = ret[15:8];
        run_op(2'd3, 16'h5555, ps, s, 1'b0);
        chk(n_edges == 5, "R7", "rets edge count", n_edges, 5);
        chk(nr == 2 && rlog_a[0] == {PAGE, s + 8'd1} && rlog_a[1] == {PAGE, s + 8'd2}, "R8",
            "rets read order", rlog_a[0], {PAGE, s + 8'd1});
        chk(pc_out == ret + 16'd1, "R6", "rets pc", pc_out, ret + 16'd1);
        chk(sp_out == s + 8'd2, "R6", "rets sp", sp_out, s + 8'd2);
        chk(ps_out == ps, "R6", "rets ps", ps_out, ps);
        after_done_checks();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) stk[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !mem_we && !mem_re, "R1", "reset strobes", {28'd0, busy, done, mem_we, mem_re}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !mem_we && !mem_re, "R1", "idle after reset", {28'd0, busy, done, mem_we, mem_re}, 0);
        chk(pc_out == 16'd0 && ps_out == 8'd0 && sp_out == 8'd0, "R1", "reset outputs", pc_out, 0);

        for (int s = 0; s < 256; s++) begin
            do_entry(2'd0, 8'(s), 1'b0);
            do_entry(2'd1, 8'(s), 1'b0);
            do_reti(8'(s));
            do_rets(8'(s), 16'h3000 ^ {8'(s), 8'(s * 3)});
        end

        // R6 program counter wrap
        do_rets(8'hFF, 16'hFFFF);

        // Round trip: break entry then return from interrupt restores context
        begin
            logic [15:0] pc;
            logic [7:0]  ps;
            logic [7:0]  sp_after;
            pc = 16'hA000 ^ {8'h01, 8'hFE};
            ps = 8'h01 ^ 8'h3C;
            do_entry(2'd1, 8'h01, 1'b0);
            sp_after = sp_out;
            run_op(2'd2, pc_out, ps_out, sp_after, 1'b0);
            chk(pc_out == pc, "R5", "round trip pc", pc_out, pc);
            chk(ps_out == (ps | 8'h10), "R3", "round trip ps", ps_out, ps | 8'h10);
            chk(sp_out == 8'h01, "R8", "round trip sp wrap", sp_out, 8'h01);
            after_done_checks();
        end

        // R9: request during a busy sequence is ignored
        begin
            logic [15:0] p_pc;
            logic [7:0]  p_sp;
            bit          quiet;
            do_entry(2'd0, 8'h40, 1'b1);
            p_pc = pc_out; p_sp = sp_out;
            quiet = 1'b1;
            for (int i = 0; i < 8; i++) begin
                if (mem_we || mem_re || busy) quiet = 1'b0;
                @(negedge clk);
            end
            chk(quiet, "R9", "no extra sequence", {31'd0, quiet}, 1);
            chk(pc_out == p_pc && sp_out == p_sp, "R9", "outputs unchanged", pc_out, p_pc);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule